// File: doc/BRIEF.md
# Flash Chip-Erase Command Sequencer

This block wipes a whole byte-wide parallel flash on an asynchronous memory bus without software involvement. A single-cycle `start` pulse makes it latch the flash window base. It then runs six byte writes in a fixed order. The first two writes are an unlock pair, followed by an erase-setup byte, a second unlock pair and the final chip-erase byte. Each address is formed as the latched base plus one of two command offsets, 0x555 or 0x2AA.

Every bus cycle has three phases, each with its own clock count: address setup with chip-enable low, an active-low strobe, and hold. The sequencer can then, if enabled, poll the flash with repeated reads. It watches bit 6 of the read data, which toggles on every read while the internal erase is running. Polling ends when two reads in a row agree. If the bit has toggled a programmable number of times without settling, polling stops and an error flag is raised. `busy` covers the whole operation and `done` pulses once at its end.

Top module: `fces_chip_erase`

## Requirements
- R1: After a start, exactly six writes appear, in this order of (address offset, data): (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x80), (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x10). The bus address is the base latched at start plus the offset, taken modulo 2^AW.
- R2: The sequencer drives the 8-bit data bus (`flash_dq_oe`=1) during write strobes. It never drives the bus while `flash_oe_n` is low, and it captures read data at the end of the read strobe.
- R3: In every bus cycle, chip-enable is low with both strobes high for `t_setup` clocks. The strobe is then low for `t_strobe` clocks. Chip-enable then stays low with both strobes high for `t_hold` clocks. A count of 0 acts as 1.
- R4: `flash_ce_n`, `flash_we_n` and `flash_oe_n` are active low. `flash_we_n` and `flash_oe_n` are never low together, and neither is low unless `flash_ce_n` is low. Chip-enable is high whenever `busy` is low.
- R5: `busy` rises on the clock edge that samples `start` while idle. `done` is a one-cycle pulse in the first cycle with `busy` low again.
- R6: A `start` pulse seen while `busy` is high is ignored. The sequence, its base address and the count of `done` pulses are unchanged.
- R7: With `poll_en`=0, the operation ends after the sixth write and no read cycles occur.
- R8: With `poll_en`=1, reads repeat until bit 6 of two consecutive reads is equal. A flash whose bit 6 toggles K times before settling is read K+2 times, with `timeout_err`=0.
- R9: If `timeout_lim` consecutive read pairs (`timeout_lim`≥1) have shown bit 6 toggling, polling stops with `timeout_err`=1. That happens after `timeout_lim`+1 reads. The flag stays set until the next accepted start clears it.
- R10: After reset, `busy`, `done`, `timeout_err` and `flash_dq_oe` are 0, and all three bus strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a chip erase |
| base_addr | input | AW | Base of the flash window, latched at start |
| t_setup | input | CW | Setup clocks per bus cycle (0 acts as 1) |
| t_strobe | input | CW | Strobe-low clocks per bus cycle (0 acts as 1) |
| t_hold | input | CW | Hold clocks per bus cycle (0 acts as 1) |
| poll_en | input | 1 | Poll the toggle bit after the sixth write |
| timeout_lim | input | TW | Toggling read pairs allowed before error |
| flash_dq_i | input | 8 | Read data from flash |
| flash_addr | output | AW | Flash address |
| flash_dq_o | output | 8 | Write data to flash |
| flash_dq_oe | output | 1 | Data bus drive enable |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Polling ended by timeout |

## Verification
The six-write pattern is swept over all 64 combinations of setup, strobe and hold counts from 0 to 3, each with a different base. One base makes the address wrap past the top of the window. These runs separate a wrong order, a wrong offset or a missing write from phase-length errors, and they show that a count of 0 is treated as 1.

For polling, a flash model settles after 0 to 5 toggles against several limits. The resulting read counts show whether the design stops on the first equal pair or times out at the boundary, where K equals the limit. Further start pulses are injected mid-sequence, and a start is issued after a timeout, to show that busy-time starts are ignored and that the error flag is cleared.

// File: rtl/fces_pkg.sv
package fces_pkg;

  localparam int unsigned NSTEPS = 6;
  localparam int unsigned SW     = 3;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_WRITE, SQ_POLL} seq_t;

  // Command offset per step: unlock pairs use both, the rest use 0x555.
  function automatic logic [11:0] step_off(input logic [SW-1:0] i);
    case (i)
      3'd1, 3'd4: step_off = 12'h2AA;
      default:    step_off = 12'h555;
    endcase
  endfunction

  function automatic logic [7:0] step_dat(input logic [SW-1:0] i);
    case (i)
      3'd0, 3'd3: step_dat = 8'hAA;
      3'd1, 3'd4: step_dat = 8'h55;
      3'd2:       step_dat = 8'h80;
      default:    step_dat = 8'h10;
    endcase
  endfunction

endpackage

// File: rtl/fces_bus_cycle.sv
module fces_bus_cycle
  import fces_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdat,
  input  logic [CW-1:0] t_setup,
  input  logic [CW-1:0] t_strobe,
  input  logic [CW-1:0] t_hold,
  input  logic [7:0]    dq_i,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_dq_o,
  output logic          bus_dq_oe,
  output logic          bus_ce_n,
  output logic          bus_we_n,
  output logic          bus_oe_n,
  output logic          ack,
  output logic [7:0]    rdata
);

  localparam logic [CW-1:0] ONE = CW'(1);

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic          rd_q;

  // Remaining-count load value: a zero count is stretched to one clock.
  function automatic logic [CW-1:0] load_of(input logic [CW-1:0] c);
    load_of = (c == '0) ? '0 : c - ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      rd_q      <= 1'b0;
      bus_addr  <= '0;
      bus_dq_o  <= '0;
      bus_dq_oe <= 1'b0;
      bus_ce_n  <= 1'b1;
      bus_we_n  <= 1'b1;
      bus_oe_n  <= 1'b1;
      ack       <= 1'b0;
      rdata     <= '0;
    end else begin
      ack <= 1'b0;
      case (ph)
        PH_IDLE: if (req) begin
          rd_q      <= rd;
          bus_addr  <= addr;
          bus_dq_o  <= wdat;
          bus_dq_oe <= !rd;
          bus_ce_n  <= 1'b0;
          cnt       <= load_of(t_setup);
          ph        <= PH_SETUP;
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            bus_we_n <= rd_q;
            bus_oe_n <= !rd_q;
            cnt      <= load_of(t_strobe);
            ph       <= PH_STROBE;
          end else cnt <= cnt - ONE;
        end
        PH_STROBE: begin
          if (cnt == '0) begin
            if (rd_q) rdata <= dq_i;
            bus_we_n <= 1'b1;
            bus_oe_n <= 1'b1;
            cnt      <= load_of(t_hold);
            ph       <= PH_HOLD;
          end else cnt <= cnt - ONE;
        end
        default: begin
          if (cnt == '0) begin
            bus_ce_n  <= 1'b1;
            bus_dq_oe <= 1'b0;
            ack       <= 1'b1;
            ph        <= PH_IDLE;
          end else cnt <= cnt - ONE;
        end
      endcase
    end
  end

  p_we_oe_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(!bus_we_n && !bus_oe_n));
  p_strobe_in_ce_r4: assert property (@(posedge clk) disable iff (rst)
    (!bus_we_n || !bus_oe_n) |-> !bus_ce_n);
  p_no_drive_on_read_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> !bus_dq_oe);
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (!bus_ce_n && $past(!bus_ce_n)) |-> $stable(bus_addr));

endmodule

// File: rtl/fces_toggle_judge.sv
module fces_toggle_judge #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          smp_vld,
  input  logic          smp_bit,
  input  logic [TW-1:0] limit,
  output logic          settled,
  output logic          expired
);

  logic          have_prev;
  logic          prev;
  logic [TW-1:0] toggles;
  logic          flip;

  assign flip    = smp_vld && have_prev && (smp_bit != prev);
  assign settled = smp_vld && have_prev && (smp_bit == prev);
  assign expired = flip && (({1'b0, toggles} + 1'b1) >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      have_prev <= 1'b0;
      prev      <= 1'b0;
      toggles   <= '0;
    end else if (smp_vld) begin
      have_prev <= 1'b1;
      prev      <= smp_bit;
      if (flip) toggles <= toggles + 1'b1;
    end
  end

  p_no_verdict_first_r8: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !have_prev) |-> !(settled || expired));

endmodule

// File: rtl/fces_chip_erase.sv
module fces_chip_erase
  import fces_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned CW = 4,
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] t_setup,
  input  logic [CW-1:0] t_strobe,
  input  logic [CW-1:0] t_hold,
  input  logic          poll_en,
  input  logic [TW-1:0] timeout_lim,
  input  logic [7:0]    flash_dq_i,
  output logic [AW-1:0] flash_addr,
  output logic [7:0]    flash_dq_o,
  output logic          flash_dq_oe,
  output logic          flash_ce_n,
  output logic          flash_we_n,
  output logic          flash_oe_n,
  output logic          busy,
  output logic          done,
  output logic          timeout_err
);

  localparam logic [SW-1:0] LAST = SW'(NSTEPS - 1);

  seq_t          sq;
  logic [SW-1:0] step;
  logic          req, rd, clr;
  logic [AW-1:0] base_q;
  logic [AW-1:0] cyc_addr;
  logic          ack;
  logic [7:0]    rdata;
  logic          settled, expired;

  assign cyc_addr = (sq == SQ_POLL) ? base_q : base_q + AW'(step_off(step));

  fces_bus_cycle #(.AW(AW), .CW(CW)) u_bus (
    .clk(clk), .rst(rst), .req(req), .rd(rd), .addr(cyc_addr),
    .wdat(step_dat(step)), .t_setup(t_setup), .t_strobe(t_strobe),
    .t_hold(t_hold), .dq_i(flash_dq_i), .bus_addr(flash_addr),
    .bus_dq_o(flash_dq_o), .bus_dq_oe(flash_dq_oe), .bus_ce_n(flash_ce_n),
    .bus_we_n(flash_we_n), .bus_oe_n(flash_oe_n), .ack(ack), .rdata(rdata)
  );

  fces_toggle_judge #(.TW(TW)) u_judge (
    .clk(clk), .rst(rst), .clear(clr),
    .smp_vld(ack && (sq == SQ_POLL)), .smp_bit(rdata[6]),
    .limit(timeout_lim), .settled(settled), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sq          <= SQ_IDLE;
      step        <= '0;
      req         <= 1'b0;
      rd          <= 1'b0;
      clr         <= 1'b0;
      base_q      <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      req  <= 1'b0;
      done <= 1'b0;
      clr  <= 1'b0;
      case (sq)
        SQ_IDLE: if (start) begin
          base_q      <= base_addr;
          busy        <= 1'b1;
          timeout_err <= 1'b0;
          step        <= '0;
          rd          <= 1'b0;
          req         <= 1'b1;
          clr         <= 1'b1;
          sq          <= SQ_WRITE;
        end
        SQ_WRITE: if (ack) begin
          if (step == LAST) begin
            if (poll_en) begin
              rd  <= 1'b1;
              req <= 1'b1;
              sq  <= SQ_POLL;
            end else begin
              busy <= 1'b0;
              done <= 1'b1;
              sq   <= SQ_IDLE;
            end
          end else begin
            step <= step + 1'b1;
            req  <= 1'b1;
          end
        end
        default: if (ack) begin
          if (settled || expired) begin
            timeout_err <= expired;
            busy        <= 1'b0;
            done        <= 1'b1;
            sq          <= SQ_IDLE;
          end else req <= 1'b1;
        end
      endcase
    end
  end

  p_busy_from_start_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(base_q));
  p_idle_bus_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> flash_ce_n);
  p_err_at_done_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err) |-> done);

endmodule

// File: tb/tb_fces_chip_erase.sv
module tb_fces_chip_erase;

  localparam int AW = 20, CW = 4, TW = 16;
  localparam int MASK = (1 << AW) - 1;

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0, poll_en = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [CW-1:0] t_setup = '0, t_strobe = '0, t_hold = '0;
  logic [TW-1:0] timeout_lim = '0;
  logic [7:0]    flash_dq_i;
  logic [AW-1:0] flash_addr;
  logic [7:0]    flash_dq_o;
  logic          flash_dq_oe, flash_ce_n, flash_we_n, flash_oe_n;
  logic          busy, done, timeout_err;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fces_chip_erase #(.AW(AW), .CW(CW), .TW(TW)) dut (.*);

  // Flash model state
  logic tog = 1'b0;
  int   kcfg = 0, kleft = 0;
  int   wr_idx = 0, seq_err = 0, bus_err = 0, tim_err = 0, nrd = 0, done_cnt = 0;
  int   su = 0, st = 0, ho = 0;
  bit   in_cyc = 0, seen_st = 0, was_rd = 0, prev_we_low = 0;
  int   cur_base = 0, es = 1, et = 1, eh = 1;

  assign flash_dq_i = {1'b0, tog, 6'b0};

  function automatic int off_of(input int i);
    return (i == 1 || i == 4) ? 'h2AA : 'h555;
  endfunction
  function automatic int dat_of(input int i);
    case (i)
      0, 3: return 'hAA;
      1, 4: return 'h55;
      2:    return 'h80;
      default: return 'h10;
    endcase
  endfunction

  always @(negedge clk) if (!rst) begin
    if (done) done_cnt++;
    if (!flash_ce_n) begin
      in_cyc = 1;
      if (!flash_we_n) begin
        if (!flash_dq_oe) bus_err++;
        if (!prev_we_low) begin
          if (!(wr_idx < 6 && int'(flash_addr) == ((cur_base + off_of(wr_idx)) & MASK)
                && int'(flash_dq_o) == dat_of(wr_idx))) seq_err++;
          wr_idx++;
          if (wr_idx == 6 && seq_err == 0) kleft = kcfg;
        end
        st++; was_rd = 0; seen_st = 1;
      end else if (!flash_oe_n) begin
        if (flash_dq_oe) bus_err++;
        st++; was_rd = 1; seen_st = 1;
      end else if (seen_st) ho++;
      else su++;
    end else if (in_cyc) begin
      if (su != es || st != et || ho != eh) tim_err++;
      if (was_rd) begin
        nrd++;
        if (kleft > 0) begin tog = ~tog; kleft--; end
      end
      su = 0; st = 0; ho = 0; seen_st = 0; in_cyc = 0; was_rd = 0;
    end
    prev_we_low = !flash_we_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int base, input int s, input int t, input int h,
                     input bit pe, input int k, input int lim, input bit extra);
    int exp_rd;
    bit exp_err;
    bit seen;
    @(negedge clk);
    base_addr = AW'(base); t_setup = CW'(s); t_strobe = CW'(t); t_hold = CW'(h);
    poll_en = pe; timeout_lim = TW'(lim);
    cur_base = base; es = (s == 0) ? 1 : s; et = (t == 0) ? 1 : t; eh = (h == 0) ? 1 : h;
    kcfg = k; kleft = 0; tog = 1'b0;
    wr_idx = 0; seq_err = 0; bus_err = 0; tim_err = 0; nrd = 0; done_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R5 and R9: busy is up and a stale error is cleared by the accepted start
    chk(busy == 1'b1, "R5 busy after start", busy, 1);
    chk(timeout_err == 1'b0, "R9 error cleared at start", timeout_err, 0);
    seen = 0;
    for (int i = 0; i < 6000 && !seen; i++) begin
      @(negedge clk);
      start = extra && (i == 5 || i == 30 || i == 61);
      if (done_cnt > 0) seen = 1;
    end
    start = 1'b0;
    chk(seen, "R5 done pulse reached", seen, 1);
    repeat (10) @(negedge clk);
    if (!pe) begin exp_rd = 0; exp_err = 0; end
    else if (k >= lim) begin exp_rd = lim + 1; exp_err = 1; end
    else begin exp_rd = k + 2; exp_err = 0; end
    chk(seq_err == 0, "R1 command order/address/data", seq_err, 0);
    chk(wr_idx == 6, extra ? "R6 six writes despite busy start" : "R1 write count", wr_idx, 6);
    chk(tim_err == 0, "R3 setup/strobe/hold lengths", tim_err, 0);
    chk(bus_err == 0, "R2 data drive only on writes", bus_err, 0);
    chk(done_cnt == 1, extra ? "R6 single done despite busy start" : "R5 single done", done_cnt, 1);
    chk(busy == 1'b0 && flash_ce_n == 1'b1, "R4 idle after done", busy, 0);
    chk(nrd == exp_rd, pe ? (exp_err ? "R9 reads at timeout" : "R8 reads until settle")
                          : "R7 no reads without polling", nrd, exp_rd);
    chk(timeout_err == exp_err, exp_err ? "R9 timeout flag held" : "R8 no timeout", timeout_err, exp_err);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(busy == 0 && done == 0 && timeout_err == 0, "R10 status after reset",
        {busy, done, timeout_err}, 0);
    chk(flash_ce_n && flash_we_n && flash_oe_n, "R10 strobes high after reset",
        {flash_ce_n, flash_we_n, flash_oe_n}, 7);
    chk(flash_dq_oe == 0, "R10 bus undriven after reset", flash_dq_oe, 0);

    // R1/R3/R7 sweep of phase counts and bases
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 4; t++)
        for (int h = 0; h < 4; h++)
          run(((s * 16 + t * 4 + h) * 'h3F1D) & MASK, s, t, h, 0, 0, 1, 0);
    run('hFFC00, 2, 1, 1, 0, 0, 1, 0);   // R1 address wrap

    // R8/R9 polling against the toggle-bit model
    for (int k = 0; k < 6; k++) run('h12345, 1, 1, 1, 1, k, 4, 0);
    run('h00800, 1, 2, 1, 1, 0, 1, 0);   // R8 settles at once with limit 1
    run('h00800, 1, 2, 1, 1, 1, 1, 0);   // R9 boundary: one toggle times out
    run('h00800, 3, 1, 2, 1, 9, 3, 0);   // R9 long erase
    run('h00800, 1, 1, 1, 1, 2, 4, 0);   // R9 cleared by this start

    // R6 starts while busy
    run('h40000, 1, 1, 1, 0, 0, 1, 1);
    run('h40000, 2, 2, 2, 1, 3, 8, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule